// File: doc/BRIEF.md
# Multi-Mode Operand Fetch and Accumulate Unit

This block runs one two-operand accumulate per command: a destination register gains a second operand, `dst <- dst + operand`. The operand comes from a small local register file, from the command's constant field, or from a data memory word found through one of several effective-address rules. The read can also go through a pointer held in memory. Some rules move the base register by the operand size once the read is complete. A sequencer picks up one command while it is idle. It drives a single-port memory read with a request/valid handshake, writes the results back and pulses `done`.

The surrounding pipeline owns instruction fetch and decode. It presents a decoded command with a mode code, three register indices, a 32-bit constant and a size code. It must wait for `done` before the next command is taken. A combinational peek port reads any register so that its state can be observed.

Top module: `addr_mode_accum`

## Requirements
- R1: After synchronous reset, every register reads zero and `busy`, `done`, `err` and `mem_req` are low.
- R2: Mode 0 adds register `cmd_base` to the destination, and mode 1 adds `cmd_const` to it. Neither mode raises `mem_req`.
- R3: Modes 2, 3, 4 and 5 make one read and add the read word to the destination. Mode 2 reads at `cmd_const + R[base]`, mode 3 at `R[base]`, mode 4 at `R[base] + R[idx]`, and mode 5 at `cmd_const`.
- R4: Mode 6 makes two reads. The first is at `R[base]` and its full 32-bit word becomes the address of the second read. The second word is the operand.
- R5: Mode 7 reads at the old `R[base]` and then adds d to `R[base]`. Mode 8 reads at the old `R[base]` and then subtracts d from `R[base]`.
- R6: Mode 9 reads at `cmd_const + R[base] + R[idx] * d`.
- R7: Size code 00 gives d = 1, code 01 gives d = 2, and codes 10 and 11 give d = 4. The final operand read is zero-extended from its low 8, 16 or 32 bits. A pointer read in mode 6 is always used as the full word.
- R8: In modes 7 and 8, when the destination equals the base, the register ends up holding the old value plus the operand. The base update is lost.
- R9: Mode codes 10 to 15 produce a `done` cycle with `err` high. They issue no read and change no register.
- R10: `mem_req` stays high with a stable `mem_addr` until the cycle in which `mem_rvalid` is sampled high. The block waits any number of cycles for it. `cmd_valid` is ignored while `busy` is high.
- R11: `busy` rises in the cycle after a command is accepted. `done` is a single-cycle pulse, and `busy` falls in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken only while idle |
| cmd_mode | input | 4 | Addressing mode code 0 to 9; 10 to 15 illegal |
| cmd_dst | input | 3 | Destination register index |
| cmd_base | input | 3 | Base register (source register in mode 0) |
| cmd_idx | input | 3 | Index register for modes 4 and 9 |
| cmd_const | input | 32 | Immediate, displacement or absolute address |
| cmd_size | input | 2 | Operand size code |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal mode, valid with `done` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid while requesting |
| mem_rdata | input | 32 | Read data word |
| peek_sel | input | 3 | Register index to observe |
| peek_data | output | 32 | Contents of the selected register |

## Verification
A wrong effective-address term shows on `mem_addr` at the first requesting cycle after acceptance. A corrupted pointer shows in the address of the second read of mode 6. Errors in the sum, the post-update or the order of the two writes stay hidden until the register file is examined through the peek port after `done`. The reference model therefore sweeps all eight registers after every command, so such an error is caught within the command that caused it. Errors in the handshake or busy sequencing show as missing, extra or early reads, or as a `done` that arrives in the wrong cycle.

// File: rtl/amu_pkg.sv
package amu_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 8;

    typedef enum logic [3:0] {
        AM_REG  = 4'd0,
        AM_IMM  = 4'd1,
        AM_DISP = 4'd2,
        AM_RIND = 4'd3,
        AM_INDX = 4'd4,
        AM_ABS  = 4'd5,
        AM_MIND = 4'd6,
        AM_AINC = 4'd7,
        AM_ADEC = 4'd8,
        AM_SCAL = 4'd9
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD1  = 2'd1,
        ST_RD2  = 2'd2,
        ST_WB   = 2'd3
    } seq_state_e;

    // decoded addressing control produced by the address generator
    typedef struct packed {
        logic uses_mem;
        logic dbl_read;
        logic upd_inc;
        logic upd_dec;
        logic bad_mode;
    } agen_ctl_t;

    // log2 of the operand byte count: 1, 2 or 4 bytes
    function automatic logic [1:0] size_log2(input logic [1:0] sz);
        case (sz)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/amu_regfile.sv
module amu_regfile #(
    parameter int W = amu_pkg::XLEN,
    parameter int N = amu_pkg::NREG,
    localparam int RI = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RI-1:0] ra_a,
    output logic [W-1:0]  rd_a,
    input  logic [RI-1:0] ra_b,
    output logic [W-1:0]  rd_b,
    input  logic [RI-1:0] ra_c,
    output logic [W-1:0]  rd_c,
    input  logic [RI-1:0] ra_d,
    output logic [W-1:0]  rd_d,
    input  logic          we_lo,
    input  logic [RI-1:0] wa_lo,
    input  logic [W-1:0]  wd_lo,
    input  logic          we_hi,
    input  logic [RI-1:0] wa_hi,
    input  logic [W-1:0]  wd_hi
);

    logic [W-1:0] regs [N];

    // the high-priority port (accumulated sum) overrides the low one
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we_hi && wa_hi == RI'(i)) begin
                regs[i] <= wd_hi;
            end else if (we_lo && wa_lo == RI'(i)) begin
                regs[i] <= wd_lo;
            end
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_c = regs[ra_c];
    assign rd_d = regs[ra_d];

endmodule

// File: rtl/amu_agen.sv
module amu_agen
    import amu_pkg::*;
#(
    parameter int W = amu_pkg::XLEN
) (
    input  logic [3:0]   mode,
    input  logic [W-1:0] cst,
    input  logic [W-1:0] base_val,
    input  logic [W-1:0] idx_val,
    input  logic [1:0]   size,
    output logic [W-1:0] ea,
    output logic [W-1:0] imm_op,
    output agen_ctl_t    ctl
);

    logic [W-1:0] scaled_idx;
    assign scaled_idx = idx_val << size_log2(size);

    always_comb begin
        ea     = base_val;
        imm_op = '0;
        ctl    = '0;
        case (mode)
            AM_REG:  imm_op = base_val;
            AM_IMM:  imm_op = cst;
            AM_DISP: begin ctl.uses_mem = 1'b1; ea = cst + base_val; end
            AM_RIND: ctl.uses_mem = 1'b1;
            AM_INDX: begin ctl.uses_mem = 1'b1; ea = base_val + idx_val; end
            AM_ABS:  begin ctl.uses_mem = 1'b1; ea = cst; end
            AM_MIND: begin ctl.uses_mem = 1'b1; ctl.dbl_read = 1'b1; end
            AM_AINC: begin ctl.uses_mem = 1'b1; ctl.upd_inc = 1'b1; end
            AM_ADEC: begin ctl.uses_mem = 1'b1; ctl.upd_dec = 1'b1; end
            AM_SCAL: begin ctl.uses_mem = 1'b1; ea = cst + base_val + scaled_idx; end
            default: ctl.bad_mode = 1'b1;
        endcase
    end

endmodule

// File: rtl/amu_seq.sv
module amu_seq
    import amu_pkg::*;
#(
    parameter int W  = amu_pkg::XLEN,
    parameter int RI = $clog2(amu_pkg::NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [RI-1:0] cmd_dst,
    input  logic [RI-1:0] cmd_base,
    input  logic [1:0]    cmd_size,
    input  logic [W-1:0]  ag_ea,
    input  logic [W-1:0]  ag_imm,
    input  agen_ctl_t     ag_ctl,
    input  logic [W-1:0]  base_val,
    input  logic [W-1:0]  dst_val,
    output logic [RI-1:0] base_sel,
    output logic [RI-1:0] dst_sel,
    input  logic          mem_rvalid,
    input  logic [W-1:0]  mem_rdata,
    output logic          mem_req,
    output logic [W-1:0]  mem_addr,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          wr_sum_en,
    output logic [W-1:0]  wr_sum_data,
    output logic          wr_upd_en,
    output logic [W-1:0]  wr_upd_data
);

    seq_state_e    state_q;
    agen_ctl_t     ctl_q;
    logic [RI-1:0] dst_q;
    logic [RI-1:0] base_q;
    logic [1:0]    size_q;
    logic [W-1:0]  addr_q;
    logic [W-1:0]  op_q;
    logic [W-1:0]  rdata_zx;
    logic [W-1:0]  step;

    always_comb begin
        case (size_q)
            2'b00:   rdata_zx = {{(W-8){1'b0}},  mem_rdata[7:0]};
            2'b01:   rdata_zx = {{(W-16){1'b0}}, mem_rdata[15:0]};
            default: rdata_zx = mem_rdata;
        endcase
    end

    assign step = W'(1) << size_log2(size_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            dst_q   <= '0;
            base_q  <= '0;
            size_q  <= '0;
            addr_q  <= '0;
            op_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (cmd_valid) begin
                    ctl_q  <= ag_ctl;
                    dst_q  <= cmd_dst;
                    base_q <= cmd_base;
                    size_q <= cmd_size;
                    addr_q <= ag_ea;
                    op_q   <= ag_imm;
                    if (!ag_ctl.bad_mode && ag_ctl.uses_mem) state_q <= ST_RD1;
                    else                                     state_q <= ST_WB;
                end
                ST_RD1: if (mem_rvalid) begin
                    if (ctl_q.dbl_read) begin
                        addr_q  <= mem_rdata;
                        state_q <= ST_RD2;
                    end else begin
                        op_q    <= rdata_zx;
                        state_q <= ST_WB;
                    end
                end
                ST_RD2: if (mem_rvalid) begin
                    op_q    <= rdata_zx;
                    state_q <= ST_WB;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign base_sel    = (state_q == ST_IDLE) ? cmd_base : base_q;
    assign dst_sel     = dst_q;
    assign busy        = (state_q != ST_IDLE);
    assign mem_req     = (state_q == ST_RD1) || (state_q == ST_RD2);
    assign mem_addr    = addr_q;
    assign done        = (state_q == ST_WB);
    assign err         = done && ctl_q.bad_mode;
    assign wr_sum_en   = done && !ctl_q.bad_mode;
    assign wr_sum_data = dst_val + op_q;
    assign wr_upd_en   = done && !ctl_q.bad_mode && (ctl_q.upd_inc || ctl_q.upd_dec);
    assign wr_upd_data = ctl_q.upd_dec ? (base_val - step) : (base_val + step);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));   // R10
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid));                                // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));                                       // R11
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && !mem_req));                                      // R9
    AST_UPD_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        wr_upd_en |-> $past(mem_rvalid && mem_req));                      // R5

endmodule

// File: rtl/addr_mode_accum.sv
module addr_mode_accum
    import amu_pkg::*;
#(
    parameter int W = amu_pkg::XLEN,
    parameter int N = amu_pkg::NREG,
    localparam int RI = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_mode,
    input  logic [RI-1:0] cmd_dst,
    input  logic [RI-1:0] cmd_base,
    input  logic [RI-1:0] cmd_idx,
    input  logic [W-1:0]  cmd_const,
    input  logic [1:0]    cmd_size,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          mem_req,
    output logic [W-1:0]  mem_addr,
    input  logic          mem_rvalid,
    input  logic [W-1:0]  mem_rdata,
    input  logic [RI-1:0] peek_sel,
    output logic [W-1:0]  peek_data
);

    logic [RI-1:0] base_sel, dst_sel;
    logic [W-1:0]  base_val, idx_val, dst_val;
    logic [W-1:0]  ag_ea, ag_imm;
    agen_ctl_t     ag_ctl;
    logic          wr_sum_en, wr_upd_en;
    logic [W-1:0]  wr_sum_data, wr_upd_data;

    amu_regfile #(.W(W), .N(N)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .ra_a  (base_sel),
        .rd_a  (base_val),
        .ra_b  (cmd_idx),
        .rd_b  (idx_val),
        .ra_c  (dst_sel),
        .rd_c  (dst_val),
        .ra_d  (peek_sel),
        .rd_d  (peek_data),
        .we_lo (wr_upd_en),
        .wa_lo (base_sel),
        .wd_lo (wr_upd_data),
        .we_hi (wr_sum_en),
        .wa_hi (dst_sel),
        .wd_hi (wr_sum_data)
    );

    amu_agen #(.W(W)) u_agen (
        .mode     (cmd_mode),
        .cst      (cmd_const),
        .base_val (base_val),
        .idx_val  (idx_val),
        .size     (cmd_size),
        .ea       (ag_ea),
        .imm_op   (ag_imm),
        .ctl      (ag_ctl)
    );

    amu_seq #(.W(W), .RI(RI)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_dst     (cmd_dst),
        .cmd_base    (cmd_base),
        .cmd_size    (cmd_size),
        .ag_ea       (ag_ea),
        .ag_imm      (ag_imm),
        .ag_ctl      (ag_ctl),
        .base_val    (base_val),
        .dst_val     (dst_val),
        .base_sel    (base_sel),
        .dst_sel     (dst_sel),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .wr_sum_en   (wr_sum_en),
        .wr_sum_data (wr_sum_data),
        .wr_upd_en   (wr_upd_en),
        .wr_upd_data (wr_upd_data)
    );

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        err |-> !(wr_sum_en || wr_upd_en));                               // R9
    AST_WRITE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        (wr_sum_en || wr_upd_en) |-> (done && !mem_req));                 // R11

endmodule

// File: tb/addr_mode_accum_bench.sv
module addr_mode_accum_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_mode = '0;
    logic [2:0]  cmd_dst = '0, cmd_base = '0, cmd_idx = '0;
    logic [31:0] cmd_const = '0;
    logic [1:0]  cmd_size = '0;
    logic        busy, done, err, mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [2:0]  peek_sel = '0;
    logic [31:0] peek_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] mref [8];

    always #4 clk = ~clk;

    addr_mode_accum u_addr_mode_accum (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_dst(cmd_dst), .cmd_base(cmd_base), .cmd_idx(cmd_idx),
        .cmd_const(cmd_const), .cmd_size(cmd_size), .busy(busy), .done(done),
        .err(err), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .peek_sel(peek_sel), .peek_data(peek_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return (a * 32'h2545_F491) ^ {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [31:0] zx(input logic [31:0] w, input logic [1:0] sz);
        if (sz == 2'b00) return {24'd0, w[7:0]};
        if (sz == 2'b01) return {16'd0, w[15:0]};
        return w;
    endfunction

    task automatic sweep(input string req);
        for (int r = 0; r < 8; r++) begin
            peek_sel = r[2:0];
            #1;
            chk(req, $sformatf("R[%0d]", r), peek_data, mref[r]);
        end
    endtask

    task automatic run(input logic [3:0] mode, input logic [2:0] dst,
                       input logic [2:0] base, input logic [2:0] idx,
                       input logic [31:0] cst, input logic [1:0] sz,
                       input int lat, input bit spur, input string req);
        logic [31:0] ea [2];
        logic [31:0] op, sum, d;
        int nexp, k, w, cyc;
        bit bad, fin;
        d    = (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
        bad  = (mode > 4'd9);
        nexp = 1;
        ea[0] = mref[base];
        ea[1] = '0;
        op = '0;
        case (mode)
            4'd0: begin nexp = 0; op = mref[base]; end
            4'd1: begin nexp = 0; op = cst; end
            4'd2: ea[0] = cst + mref[base];
            4'd4: ea[0] = mref[base] + mref[idx];
            4'd5: ea[0] = cst;
            4'd6: begin nexp = 2; ea[1] = memfn(mref[base]); end
            4'd9: ea[0] = cst + mref[base] + mref[idx] * d;
            default: if (bad) nexp = 0;
        endcase
        if (nexp > 0) op = zx(memfn(ea[nexp-1]), sz);

        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = mode; cmd_dst = dst; cmd_base = base;
        cmd_idx = idx; cmd_const = cst; cmd_size = sz;
        @(negedge clk);
        chk("R11", "busy after accept", {31'd0, busy}, 32'd1);
        k = 0; w = 0; cyc = 0; fin = 0;
        while (!fin) begin
            cmd_valid  = 1'b0;
            mem_rvalid = 1'b0;
            if (done) begin
                chk(req, "err at done", {31'd0, err}, {31'd0, bad});
                chk(req, "read count", k, nexp);
                fin = 1;
            end else begin
                if (mem_req) begin
                    if (k >= nexp) begin
                        chk(req, "unexpected read addr", mem_addr, 32'hFFFF_FFFF);
                        k++;
                    end else begin
                        chk(k == 0 ? req : "R4", $sformatf("read %0d addr", k), mem_addr, ea[k]);
                        if (spur && k == 0 && w == 0) begin
                            // R10: command offered while busy must be ignored
                            cmd_valid = 1'b1; cmd_mode = 4'd1; cmd_dst = dst;
                            cmd_const = 32'h0000_7777;
                        end
                        if (w >= lat) begin
                            mem_rvalid = 1'b1;
                            mem_rdata  = memfn(mem_addr);
                            k++; w = 0;
                        end else begin
                            w++;
                        end
                    end
                end
                cyc++;
                if (cyc > 400) begin
                    chk(req, "watchdog: done never seen", 32'd0, 32'd1);
                    fin = 1;
                end
                @(negedge clk);
            end
        end
        if (!bad) begin
            sum = mref[dst] + op;
            if (mode == 4'd7) mref[base] = mref[base] + d;
            if (mode == 4'd8) mref[base] = mref[base] - d;
            mref[dst] = sum;
        end
        @(negedge clk);
        chk("R11", "busy low after done", {31'd0, busy}, 32'd0);
        sweep(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] s;
        for (int r = 0; r < 8; r++) mref[r] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "busy", {31'd0, busy}, 32'd0);
        chk("R1", "done", {31'd0, done}, 32'd0);
        chk("R1", "err", {31'd0, err}, 32'd0);
        chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);
        sweep("R1");

        // R2 immediate loads of every register, then register-direct adds
        run(4'd1, 3'd0, 3'd0, 3'd0, 32'h0000_0100, 2'b10, 0, 0, "R2");
        run(4'd1, 3'd1, 3'd0, 3'd0, 32'h0000_2000, 2'b10, 0, 0, "R2");
        run(4'd1, 3'd2, 3'd0, 3'd0, 32'h0000_0003, 2'b10, 0, 0, "R2");
        run(4'd1, 3'd3, 3'd0, 3'd0, 32'h0000_0040, 2'b10, 0, 0, "R2");
        run(4'd1, 3'd4, 3'd0, 3'd0, 32'h0000_0010, 2'b10, 0, 0, "R2");
        run(4'd1, 3'd5, 3'd0, 3'd0, 32'hFFFF_FF00, 2'b10, 0, 0, "R2");
        run(4'd1, 3'd6, 3'd0, 3'd0, 32'h0000_0005, 2'b10, 0, 0, "R2");
        run(4'd0, 3'd7, 3'd2, 3'd0, 32'h0, 2'b00, 0, 0, "R2");
        run(4'd0, 3'd6, 3'd6, 3'd0, 32'h0, 2'b00, 0, 0, "R2");

        // R3 single-read modes with several latencies
        run(4'd2, 3'd6, 3'd1, 3'd0, 32'h0000_0024, 2'b10, 2, 0, "R3");
        run(4'd3, 3'd7, 3'd0, 3'd0, 32'h0, 2'b10, 0, 0, "R3");
        run(4'd4, 3'd2, 3'd1, 3'd4, 32'h0, 2'b10, 5, 0, "R3");
        run(4'd5, 3'd3, 3'd7, 3'd7, 32'h000D_EAD0, 2'b10, 1, 0, "R3");
        // R10 ignored command while waiting for read data
        run(4'd3, 3'd4, 3'd3, 3'd0, 32'h0, 2'b10, 3, 1, "R10");
        // R4 pointer chase, narrow final operand
        run(4'd6, 3'd5, 3'd0, 3'd0, 32'h0, 2'b01, 2, 0, "R4");
        run(4'd6, 3'd1, 3'd4, 3'd0, 32'h0, 2'b00, 0, 1, "R4");
        // R5 post-update, each size
        run(4'd7, 3'd0, 3'd1, 3'd0, 32'h0, 2'b10, 1, 0, "R5");
        run(4'd7, 3'd0, 3'd1, 3'd0, 32'h0, 2'b01, 0, 0, "R5");
        run(4'd8, 3'd2, 3'd3, 3'd0, 32'h0, 2'b00, 2, 0, "R5");
        run(4'd8, 3'd2, 3'd3, 3'd0, 32'h0, 2'b11, 0, 0, "R5");
        // R6 scaled index with every scale
        run(4'd9, 3'd7, 3'd1, 3'd2, 32'h0000_0100, 2'b10, 1, 0, "R6");
        run(4'd9, 3'd7, 3'd1, 3'd2, 32'h0000_0100, 2'b01, 0, 0, "R6");
        run(4'd9, 3'd6, 3'd3, 3'd6, 32'hFFFF_FFF0, 2'b00, 3, 0, "R6");
        // R7 zero extension of byte and halfword
        run(4'd5, 3'd4, 3'd0, 3'd0, 32'h0000_1234, 2'b00, 0, 0, "R7");
        run(4'd5, 3'd4, 3'd0, 3'd0, 32'h0000_1234, 2'b01, 0, 0, "R7");
        // R8 destination equals base: sum wins
        run(4'd7, 3'd1, 3'd1, 3'd0, 32'h0, 2'b10, 1, 0, "R8");
        run(4'd8, 3'd3, 3'd3, 3'd0, 32'h0, 2'b01, 0, 0, "R8");
        // R9 illegal codes
        run(4'd10, 3'd0, 3'd1, 3'd2, 32'h0000_0055, 2'b10, 0, 0, "R9");
        run(4'd15, 3'd5, 3'd5, 3'd5, 32'hFFFF_FFFF, 2'b00, 0, 0, "R9");

        // mixed pseudo-random commands across all codes
        s = 32'hACE1_2468;
        for (int i = 0; i < 60; i++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            run(s[31:28], s[27:25], s[24:22], s[21:19], {16'd0, s[15:0]},
                s[18:17], int'(s[5:4]), s[6], "R3");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule